// File: doc/BRIEF.md
# Dual Multiply-With-Carry Random Word Generator

This block produces a stream of 32-bit pseudo-random words from two independent multiply-with-carry lanes, called z and w. On each accepted step, each lane multiplies its low half by a fixed constant and adds its high half. The new z (moved up by 16 bits) and the new w are then summed into one output word. The output sits in a register and is flagged valid for one cycle.

A synchronous seed-load path scrambles a 32-bit seed into both lanes. A lane that would load as all-zero gets a fixed nonzero substitute instead, because an all-zero multiply-with-carry state never leaves zero. Reset puts fixed, nonzero start constants into both lanes, so a generator that is never seeded still yields a defined sequence. A step can be requested every cycle.

Top module: `mwc_rng`

## Requirements
- R1: During and right after reset, `rndValid` is 0 and `rndOut` is 0. Reset loads lane w with 0x23E866ED and lane z with 0x80FD5AF2, so the first step after reset produces the word derived from those constants.
- R2: When `seedLoad` is high at a clock edge, lane w loads `seedIn ^ (seedIn << 16)` truncated to 32 bits, and lane z loads `~seedIn`.
- R3: If the seed-derived w value is zero, w loads 1337 (decimal) instead. If the seed-derived z value is zero, z loads 31337 (decimal) instead. Seed 0 and seed 0xFFFFFFFF hit these two cases.
- R4: Each step sets z to 36969 * z[15:0] + z[31:16], modulo 2^32.
- R5: Each step sets w to 18000 * w[15:0] + w[31:16], modulo 2^32.
- R6: A step requested at a clock edge (with `stepReq` high and `seedLoad` low) puts `(zNew << 16) + wNew` mod 2^32 on `rndOut`, and raises `rndValid`, for the cycle after that edge. One valid pulse appears per accepted step, so back-to-back requests give back-to-back words.
- R7: If `seedLoad` and `stepReq` are high at the same edge, the seed load wins. No step happens, `rndValid` stays 0 in the following cycle, and the next step continues from the seeded state.
- R8: In a cycle with no accepted step, `rndValid` is 0 and `rndOut` keeps its last value. Lane states are held, so a later step continues the sequence as if there had been no gap.
- R9: Neither lane state is ever zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| seedLoad | input | 1 | Load both lanes from `seedIn` this edge |
| seedIn | input | 32 | Seed value |
| stepReq | input | 1 | Request one generator step |
| rndOut | output | 32 | Registered random word |
| rndValid | output | 1 | `rndOut` holds a fresh word this cycle |

## Verification
The bench runs long bursts of steps, both from the reset constants and from seeds 0 and 0xFFFFFFFF, and compares each word with a model of the recurrence. These seeds force the zero-substitute constants: a design that dropped the substitution would lock one lane at zero, and its output would decay to a single-lane pattern. Mixing up the z and w multipliers, or dropping the carry half, makes the very first word differ. A simultaneous seed-and-step shows whether a design wrongly advances or flags a word on a load. Idle gaps between steps reveal an output that is not held, or a state that drifts while no step is requested.

// File: rtl/mwc_rng_pkg.sv
package mwc_rng_pkg;

  localparam int RNG_WIDTH  = 32;
  localparam int LANE_COUNT = 2;

  // lane index 0 is z, lane index 1 is w
  localparam int LANE_Z = 0;
  localparam int LANE_W = 1;

  localparam logic [RNG_WIDTH-1:0] LANE_MULT [LANE_COUNT] =
    '{32'd36969, 32'd18000};
  localparam logic [RNG_WIDTH-1:0] LANE_RESET [LANE_COUNT] =
    '{32'h80FD5AF2, 32'h23E866ED};
  localparam logic [RNG_WIDTH-1:0] LANE_ZERO_SUB [LANE_COUNT] =
    '{32'd31337, 32'd1337};

  typedef struct packed {
    logic loadSeed;
    logic advance;
  } rngStrobe_t;

endpackage

// File: rtl/mwc_lane.sv
module mwc_lane #(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] MULT = '1,
  parameter logic [WIDTH-1:0] RESET_VAL = '1,
  parameter logic [WIDTH-1:0] ZERO_SUB = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic             stepEn,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] stateQ,
  output logic [WIDTH-1:0] stateNext
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] lowExt;
  logic [WIDTH-1:0] highExt;
  logic [WIDTH-1:0] product;
  logic [WIDTH-1:0] loadFixed;

  always_comb begin
    lowExt    = {{(WIDTH-HALF){1'b0}}, stateQ[HALF-1:0]};
    highExt   = {{HALF{1'b0}}, stateQ[WIDTH-1:HALF]};
    product   = MULT * lowExt;
    stateNext = product + highExt;
    loadFixed = (loadVal == '0) ? ZERO_SUB : loadVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= RESET_VAL;
    end else if (loadEn) begin
      stateQ <= loadFixed;
    end else if (stepEn) begin
      stateQ <= stateNext;
    end
  end

  // R9: a lane never holds zero
  a_r9_lane_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    stateQ != '0);

  // R8: state held when neither load nor step
  a_r8_lane_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !stepEn) |=> $stable(stateQ));

endmodule

// File: rtl/mwc_rng_ctrl.sv
module mwc_rng_ctrl
  import mwc_rng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       seedLoad,
  input  logic       stepReq,
  output rngStrobe_t strobe,
  output logic       validQ
);

  always_comb begin
    strobe.loadSeed = seedLoad;
    strobe.advance  = stepReq & ~seedLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else begin
      validQ <= strobe.advance;
    end
  end

  // R7: a seed load never yields a valid word
  a_r7_load_beats_step: assert property (@(posedge clk) disable iff (!rstN)
    seedLoad |=> !validQ);

  // R6: a valid pulse follows a requested step
  a_r6_valid_follows_step: assert property (@(posedge clk) disable iff (!rstN)
    (stepReq && !seedLoad) |=> validQ);

  // R8: no request, no valid
  a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !stepReq |=> !validQ);

endmodule

// File: rtl/mwc_rng_datapath.sv
module mwc_rng_datapath
  import mwc_rng_pkg::*;
#(
  parameter int WIDTH = RNG_WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  rngStrobe_t       strobe,
  input  logic [WIDTH-1:0] seedIn,
  output logic [WIDTH-1:0] rndQ
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] laneLoad  [LANE_COUNT];
  logic [WIDTH-1:0] laneState [LANE_COUNT];
  logic [WIDTH-1:0] laneNext  [LANE_COUNT];
  logic [WIDTH-1:0] mixedWord;

  always_comb begin
    laneLoad[LANE_Z] = ~seedIn;
    laneLoad[LANE_W] = seedIn ^ (seedIn << HALF);
  end

  for (genvar g = 0; g < LANE_COUNT; g++) begin : gLane
    mwc_lane #(
      .WIDTH    (WIDTH),
      .MULT     (WIDTH'(LANE_MULT[g])),
      .RESET_VAL(WIDTH'(LANE_RESET[g])),
      .ZERO_SUB (WIDTH'(LANE_ZERO_SUB[g]))
    ) uLane (
      .clk      (clk),
      .rstN     (rstN),
      .loadEn   (strobe.loadSeed),
      .stepEn   (strobe.advance),
      .loadVal  (laneLoad[g]),
      .stateQ   (laneState[g]),
      .stateNext(laneNext[g])
    );
  end

  assign mixedWord = (laneNext[LANE_Z] << HALF) + laneNext[LANE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rndQ <= '0;
    end else if (strobe.advance) begin
      rndQ <= mixedWord;
    end
  end

  // R8: output word held between steps
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(rndQ));

  // R7: a load moves both lanes together with no output update
  a_r7_load_no_output: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadSeed |=> $stable(rndQ));

endmodule

// File: rtl/mwc_rng.sv
module mwc_rng
  import mwc_rng_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        seedLoad,
  input  logic [31:0] seedIn,
  input  logic        stepReq,
  output logic [31:0] rndOut,
  output logic        rndValid
);

  rngStrobe_t strobe;

  mwc_rng_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .seedLoad(seedLoad),
    .stepReq (stepReq),
    .strobe  (strobe),
    .validQ  (rndValid)
  );

  mwc_rng_datapath #(.WIDTH(RNG_WIDTH)) uData (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .seedIn(seedIn),
    .rndQ  (rndOut)
  );

endmodule

// File: tb/mwc_rng_bench.sv
module mwc_rng_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        seedLoad = 1'b0;
  logic [31:0] seedIn = '0;
  logic        stepReq = 1'b0;
  logic [31:0] rndOut;
  logic        rndValid;

  int checks = 0;
  int fails  = 0;
  logic [31:0] refZ, refW, lastOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  mwc_rng u_mwc_rng (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .seedIn(seedIn),
    .stepReq(stepReq), .rndOut(rndOut), .rndValid(rndValid)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // software model of the recurrence
  function automatic logic [31:0] refNext();
    refZ = 32'd36969 * {16'd0, refZ[15:0]} + {16'd0, refZ[31:16]};
    refW = 32'd18000 * {16'd0, refW[15:0]} + {16'd0, refW[31:16]};
    return (refZ << 16) + refW;
  endfunction

  task automatic refSeed(input logic [31:0] s);
    refW = s ^ (s << 16);
    if (refW == 0) refW = 32'd1337;
    refZ = ~s;
    if (refZ == 0) refZ = 32'd31337;
  endtask

  task automatic runSteps(input int n, input string req);
    logic [31:0] exp;
    stepReq = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      exp = refNext();
      check(rndValid === 1'b1, {req, " valid"}, {31'd0, rndValid}, 32'd1);
      check(rndOut === exp, req, rndOut, exp);
    end
    stepReq = 1'b0;
    lastOut = rndOut;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(rndValid === 1'b0, "R1 reset valid", {31'd0, rndValid}, 32'd0);
    check(rndOut === 32'd0, "R1 reset out", rndOut, 32'd0);
    rstN = 1'b1;
    refZ = 32'h80FD5AF2;
    refW = 32'h23E866ED;
    @(negedge clk);
    check(rndValid === 1'b0, "R1 idle after reset", {31'd0, rndValid}, 32'd0);
    runSteps(1000, "R1 R4 R5 R6 from reset");
  endtask

  task automatic testSeed(input logic [31:0] s, input int n, input string req);
    @(negedge clk);
    seedIn = s; seedLoad = 1'b1;
    @(negedge clk);
    seedLoad = 1'b0;
    refSeed(s);
    check(rndValid === 1'b0, {req, " load no valid"}, {31'd0, rndValid}, 32'd0);
    runSteps(n, req);
  endtask

  task automatic testIdleGap();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rndValid === 1'b0, "R8 idle valid", {31'd0, rndValid}, 32'd0);
      check(rndOut === lastOut, "R8 idle hold", rndOut, lastOut);
    end
    runSteps(20, "R8 resume after gap");
    // single steps separated by idles
    for (int k = 0; k < 10; k++) begin
      runSteps(1, "R6 single step");
      @(negedge clk);
      check(rndValid === 1'b0, "R6 single pulse", {31'd0, rndValid}, 32'd0);
    end
  endtask

  task automatic testCollide(input logic [31:0] s);
    @(negedge clk);
    seedIn = s; seedLoad = 1'b1; stepReq = 1'b1;
    @(negedge clk);
    seedLoad = 1'b0; stepReq = 1'b0;
    refSeed(s);
    check(rndValid === 1'b0, "R7 collide valid", {31'd0, rndValid}, 32'd0);
    check(rndOut === lastOut, "R7 collide out held", rndOut, lastOut);
    runSteps(50, "R7 continue from seed");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    testReset();
    testSeed(32'h0000_0000, 1000, "R2 R3 seed zero");
    testSeed(32'hFFFF_FFFF, 1000, "R2 R3 seed ones");
    testSeed(32'h1234_ABCD, 200, "R2 seed mixed");
    testIdleGap();
    testCollide(32'hDEAD_0001);
    testSeed(32'h0001_0000, 100, "R9 sparse seed");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule